// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block carries out 32-bit atomic memory operations for a small RISC-V style core. The core hands over one instruction word with the values of its two source registers. The block checks the encoding and picks one of eight combining operations: add, exclusive-or, or, and, and signed or unsigned minimum and maximum. It reads one word from memory and combines that word with the source operand. It then writes the result back to the same address. The word it read goes to the destination register, never the combined value.

Memory sits behind a plain request/response port. A request lasts one cycle and is later answered by one response, which can carry an error flag. The unit has three ways to end an operation early. A bad encoding raises an illegal-instruction strobe, and an unaligned address raises a misaligned strobe; neither touches memory. An error on either memory response raises an access-fault strobe and drops the register update. The unit handles one operation at a time. From acceptance until its final strobe it is busy and takes nothing new.

Top module: `amo_unit`

## Requirements
- R1: An instruction is taken as an atomic word operation only when bits 6:0 equal 0x2F and bits 14:12 equal 2. Any other value in either field produces a one-cycle `exc_illegal` pulse and no memory access.
- R2: Bits 31:27 select the operation. 0x00 is add with wrap-around, 0x04 is xor, 0x08 is or, 0x0C is and, 0x10 is signed minimum, 0x14 is signed maximum, 0x18 is unsigned minimum and 0x1C is unsigned maximum. The first operand is the memory word and the second is the source operand.
- R3: Any other selector value produces `exc_illegal` and no memory access.
- R4: The memory address is `req_rs1_val` and the source operand is `req_rs2_val`. The destination index is taken from instruction bits 11:7.
- R5: The destination register receives the word read from memory. Memory receives the combined result.
- R6: The write request goes to the same address as the read, and only after the read response returns without error.
- R7: A read response with the error flag set produces `exc_access` and ends the operation. No write request follows and there is no register write.
- R8: A write response with the error flag set produces `exc_access`. There is no `done` and no register write.
- R9: `rd_we` and `done` pulse together for one cycle, in the cycle after an error-free write response. When the destination index is 0, `done` still pulses and `rd_we` stays low.
- R10: Instruction bits 26:25 have no effect on the outcome.
- R11: An address with either of its two low bits set produces `exc_misalign` and no memory access. An illegal encoding takes priority over a misaligned address.
- R12: `req_ready` is low from acceptance until the operation's final strobe. Requests presented while it is low are ignored.
- R13: In any cycle, at most one of `done`, `exc_illegal`, `exc_access` and `exc_misalign` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Instruction offered |
| req_ready | output | 1 | Unit idle; an offered instruction is accepted on this edge |
| req_insn | input | 32 | Instruction word |
| req_rs1_val | input | XLEN | Address register value |
| req_rs2_val | input | XLEN | Source operand register value |
| mem_req_valid | output | 1 | One-cycle memory request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | XLEN | Word address |
| mem_req_wdata | output | XLEN | Write data |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rsp_err | input | 1 | Response reports an access error |
| mem_rsp_rdata | input | XLEN | Read data |
| rd_we | output | 1 | Destination register write strobe |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | XLEN | Old memory value for the register file |
| done | output | 1 | Operation completed |
| exc_illegal | output | 1 | Illegal encoding strobe |
| exc_access | output | 1 | Memory access fault strobe |
| exc_misalign | output | 1 | Misaligned address strobe |

## Verification
The bench uses the default `XLEN` of 32. At that width the signed/unsigned split sits at 0x8000_0000 and add wraps past 0xFFFF_FFFF. Both are driven directly, so swapping signed and unsigned compares, or mishandling the carry, changes the expected results. A memory model in the bench answers each request one cycle later and can inject an error on the read or the write separately. It counts requests, so the bench can see that illegal, misaligned and read-faulted operations stop short of memory.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam logic [6:0] OPC_ATOMIC = 7'h2F;
    localparam logic [2:0] WIDTH_WORD = 3'd2;

    typedef enum logic [2:0] {
        OP_ADD, OP_XOR, OP_OR, OP_AND, OP_MIN, OP_MAX, OP_MINU, OP_MAXU
    } amo_op_e;

    typedef struct packed {
        logic    ok;
        amo_op_e op;
    } sel_map_t;

    typedef struct packed {
        logic       legal;
        amo_op_e    op;
        logic [4:0] rd;
    } amo_dec_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT
    } amo_state_e;

    function automatic sel_map_t map_selector(input logic [4:0] sel);
        sel_map_t m;
        m.ok = 1'b1;
        m.op = OP_ADD;
        case (sel)
            5'h00: m.op = OP_ADD;
            5'h04: m.op = OP_XOR;
            5'h08: m.op = OP_OR;
            5'h0C: m.op = OP_AND;
            5'h10: m.op = OP_MIN;
            5'h14: m.op = OP_MAX;
            5'h18: m.op = OP_MINU;
            5'h1C: m.op = OP_MAXU;
            default: m.ok = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
(
    input  logic [31:0] insn,
    output amo_dec_t    dec
);
    sel_map_t sel_m;
    logic     unused_fields;

    assign unused_fields = ^insn[26:15];

    always_comb begin
        sel_m     = map_selector(insn[31:27]);
        dec.op    = sel_m.op;
        dec.rd    = insn[11:7];
        dec.legal = (insn[6:0] == OPC_ATOMIC) &&
                    (insn[14:12] == WIDTH_WORD) && sel_m.ok;
    end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  amo_op_e          op,
    input  logic [XLEN-1:0]  mem_val,
    input  logic [XLEN-1:0]  src_val,
    output logic [XLEN-1:0]  result
);
    logic s_lt, u_lt;

    always_comb begin
        s_lt = $signed(mem_val) < $signed(src_val);
        u_lt = mem_val < src_val;
        case (op)
            OP_ADD:  result = mem_val + src_val;
            OP_XOR:  result = mem_val ^ src_val;
            OP_OR:   result = mem_val | src_val;
            OP_AND:  result = mem_val & src_val;
            OP_MIN:  result = s_lt ? mem_val : src_val;
            OP_MAX:  result = s_lt ? src_val : mem_val;
            OP_MINU: result = u_lt ? mem_val : src_val;
            default: result = u_lt ? src_val : mem_val;
        endcase
    end

    always_comb begin
        if (op inside {OP_MINU, OP_MAXU, OP_MIN, OP_MAX})
            assert_minmax_pick_R2: assert (result == mem_val || result == src_val);
    end
endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
    import amo_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  amo_dec_t         dec,
    input  logic [XLEN-1:0]  rs1_val,
    input  logic [XLEN-1:0]  rs2_val,
    output amo_op_e          op_q,
    output logic [XLEN-1:0]  old_q,
    output logic [XLEN-1:0]  src_q,
    input  logic [XLEN-1:0]  alu_res,
    output logic             mem_req_valid,
    output logic             mem_req_we,
    output logic [XLEN-1:0]  mem_req_addr,
    output logic [XLEN-1:0]  mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic             mem_rsp_err,
    input  logic [XLEN-1:0]  mem_rsp_rdata,
    output logic             rd_we,
    output logic [4:0]       rd_idx,
    output logic [XLEN-1:0]  rd_data,
    output logic             done,
    output logic             exc_illegal,
    output logic             exc_access,
    output logic             exc_misalign
);
    localparam int BYTE_OFS = $clog2(XLEN / 8);

    amo_state_e      state;
    logic [XLEN-1:0] addr_q;
    logic            accept;

    assign req_ready     = (state == ST_IDLE);
    assign accept        = req_valid && req_ready;
    assign mem_req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
    assign mem_req_we    = (state == ST_WR_REQ);
    assign mem_req_addr  = addr_q;
    assign mem_req_wdata = alu_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            addr_q       <= '0;
            src_q        <= '0;
            old_q        <= '0;
            op_q         <= OP_ADD;
            rd_idx       <= '0;
            rd_data      <= '0;
            rd_we        <= 1'b0;
            done         <= 1'b0;
            exc_illegal  <= 1'b0;
            exc_access   <= 1'b0;
            exc_misalign <= 1'b0;
        end else begin
            rd_we        <= 1'b0;
            done         <= 1'b0;
            exc_illegal  <= 1'b0;
            exc_access   <= 1'b0;
            exc_misalign <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    if (!dec.legal) begin
                        exc_illegal <= 1'b1;
                    end else if (rs1_val[BYTE_OFS-1:0] != '0) begin
                        exc_misalign <= 1'b1;
                    end else begin
                        addr_q <= rs1_val;
                        src_q  <= rs2_val;
                        op_q   <= dec.op;
                        rd_idx <= dec.rd;
                        state  <= ST_RD_REQ;
                    end
                end
                ST_RD_REQ: state <= ST_RD_WAIT;
                ST_RD_WAIT: if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        exc_access <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        old_q <= mem_rsp_rdata;
                        state <= ST_WR_REQ;
                    end
                end
                ST_WR_REQ: state <= ST_WR_WAIT;
                ST_WR_WAIT: if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        exc_access <= 1'b1;
                    end else begin
                        done    <= 1'b1;
                        rd_we   <= (rd_idx != 5'd0);
                        rd_data <= old_q;
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Early exits leave memory untouched
    assert_illegal_no_access_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && !dec.legal) |=> !mem_req_valid);
    assert_misalign_no_access_R11: assert property (@(posedge clk) disable iff (rst)
        (accept && rs1_val[BYTE_OFS-1:0] != '0) |=> !mem_req_valid);
    assert_write_after_good_read_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_we) |-> $past(mem_rsp_valid && !mem_rsp_err));
    assert_read_fault_stops_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_WAIT && mem_rsp_valid && mem_rsp_err)
        |=> (!mem_req_valid && !rd_we && !done && exc_access));
    assert_write_fault_no_done_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR_WAIT && mem_rsp_valid && mem_rsp_err) |=> (!done && !rd_we));
    assert_done_after_good_write_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_rsp_valid && !mem_rsp_err));
    assert_x0_discarded_R9: assert property (@(posedge clk) disable iff (rst)
        rd_we |-> (done && rd_idx != 5'd0));
    assert_busy_ignores_R12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (!exc_illegal && !exc_misalign));
    assert_single_outcome_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, exc_illegal, exc_access, exc_misalign}));
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_insn,
    input  logic [XLEN-1:0]  req_rs1_val,
    input  logic [XLEN-1:0]  req_rs2_val,
    output logic             mem_req_valid,
    output logic             mem_req_we,
    output logic [XLEN-1:0]  mem_req_addr,
    output logic [XLEN-1:0]  mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic             mem_rsp_err,
    input  logic [XLEN-1:0]  mem_rsp_rdata,
    output logic             rd_we,
    output logic [4:0]       rd_idx,
    output logic [XLEN-1:0]  rd_data,
    output logic             done,
    output logic             exc_illegal,
    output logic             exc_access,
    output logic             exc_misalign
);
    amo_dec_t        dec;
    amo_op_e         op_q;
    logic [XLEN-1:0] old_q, src_q, alu_res;

    amo_decode u_decode (
        .insn (req_insn),
        .dec  (dec)
    );

    amo_alu #(.XLEN(XLEN)) u_alu (
        .op      (op_q),
        .mem_val (old_q),
        .src_val (src_q),
        .result  (alu_res)
    );

    amo_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .dec           (dec),
        .rs1_val       (req_rs1_val),
        .rs2_val       (req_rs2_val),
        .op_q          (op_q),
        .old_q         (old_q),
        .src_q         (src_q),
        .alu_res       (alu_res),
        .mem_req_valid (mem_req_valid),
        .mem_req_we    (mem_req_we),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_err   (mem_rsp_err),
        .mem_rsp_rdata (mem_rsp_rdata),
        .rd_we         (rd_we),
        .rd_idx        (rd_idx),
        .rd_data       (rd_data),
        .done          (done),
        .exc_illegal   (exc_illegal),
        .exc_access    (exc_access),
        .exc_misalign  (exc_misalign)
    );
endmodule

// File: tb/test_amo_unit.sv
`timescale 1ns/1ps
module test_amo_unit;
    localparam int XLEN   = 32;
    localparam int K_DONE = 0;
    localparam int K_ILL  = 1;
    localparam int K_ACC  = 2;
    localparam int K_MIS  = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_ready;
    logic [31:0] req_insn = '0;
    logic [XLEN-1:0] req_rs1_val = '0, req_rs2_val = '0;
    logic mem_req_valid, mem_req_we;
    logic [XLEN-1:0] mem_req_addr, mem_req_wdata;
    logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
    logic [XLEN-1:0] mem_rsp_rdata = '0;
    logic rd_we, done, exc_illegal, exc_access, exc_misalign;
    logic [4:0] rd_idx;
    logic [XLEN-1:0] rd_data;

    always #10 clk = ~clk;

    amo_unit #(.XLEN(XLEN)) i_amo_unit (.*);

    typedef struct {
        int          kind;
        logic        we;
        logic [4:0]  idx;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: answers one cycle after each request
    logic [31:0] mem_arr [0:15];
    logic        pend = 1'b0, p_we = 1'b0;
    logic [3:0]  p_idx = '0;
    logic [31:0] p_wdata = '0, p_addr = '0, last_rd_addr = 32'hFFFF_FFFF;
    int          acc_cnt = 0;
    bit          flt_rd = 0, flt_wr = 0;

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_err   = p_we ? flt_wr : flt_rd;
            mem_rsp_rdata = mem_arr[p_idx];
            if (!p_we && !flt_rd) last_rd_addr = p_addr;
            if (p_we && !flt_wr) mem_arr[p_idx] = p_wdata;
            pend = 1'b0;
        end
        if (!rst && mem_req_valid) begin
            if (mem_req_we)
                chk(mem_req_addr == last_rd_addr, "R6 write address vs good read",
                    mem_req_addr, last_rd_addr);
            if (!mem_req_we) last_rd_addr = 32'hFFFF_FFFF;
            pend = 1'b1; p_we = mem_req_we; p_idx = mem_req_addr[5:2];
            p_addr = mem_req_addr; p_wdata = mem_req_wdata;
            acc_cnt++;
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            int k;
            k = done ? K_DONE : exc_illegal ? K_ILL : exc_access ? K_ACC :
                exc_misalign ? K_MIS : -1;
            if (k >= 0) begin
                chk($countones({done, exc_illegal, exc_access, exc_misalign}) == 1,
                    "R13 single outcome", {28'd0, done, exc_illegal, exc_access, exc_misalign}, 0);
                if (exp_q.size() == 0) begin
                    chk(0, "R12 unexpected outcome", k, 32'hFFFF_FFFF);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(k == e.kind, {e.tag, " outcome"}, k, e.kind);
                    chk(rd_we == e.we, {e.tag, " rd_we"}, {31'd0, rd_we}, {31'd0, e.we});
                    if (e.we) begin
                        chk(rd_idx == e.idx, {e.tag, " rd_idx R4"}, {27'd0, rd_idx}, {27'd0, e.idx});
                        chk(rd_data == e.data, {e.tag, " rd_data R5"}, rd_data, e.data);
                    end
                end
            end
        end
    end

    function automatic logic [31:0] mk(input logic [4:0] sel, input logic [1:0] hint,
                                       input logic [2:0] f3, input logic [4:0] rd,
                                       input logic [6:0] opc);
        return {sel, hint, 5'd6, 5'd3, f3, rd, opc};
    endfunction

    function automatic logic [31:0] ref_op(input logic [4:0] sel,
                                           input logic [31:0] m, input logic [31:0] s);
        case (sel)
            5'h00: return m + s;
            5'h04: return m ^ s;
            5'h08: return m | s;
            5'h0C: return m & s;
            5'h10: return ($signed(m) <= $signed(s)) ? m : s;
            5'h14: return ($signed(m) >= $signed(s)) ? m : s;
            5'h18: return (m <= s) ? m : s;
            default: return (m >= s) ? m : s;
        endcase
    endfunction

    task automatic issue(input logic [31:0] insn, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_insn = insn; req_rs1_val = a; req_rs2_val = b;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_op(input string tag, input logic [31:0] insn, input logic [31:0] addr,
                          input logic [31:0] init, input logic [31:0] src,
                          input bit rf, input bit wf, input int kind);
        exp_t e;
        int a0, exp_acc;
        logic [31:0] exp_mem;
        flt_rd = rf; flt_wr = wf;
        mem_arr[addr[5:2]] = init;
        a0 = acc_cnt;
        e.kind = kind; e.tag = tag; e.idx = insn[11:7]; e.data = init;
        e.we = (kind == K_DONE) && (insn[11:7] != 5'd0);
        exp_q.push_back(e);
        exp_mem = (kind == K_DONE) ? ref_op(insn[31:27], init, src) : init;
        exp_acc = (kind == K_DONE || (kind == K_ACC && !rf)) ? 2 : (kind == K_ACC) ? 1 : 0;
        issue(insn, addr, src);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(mem_arr[addr[5:2]] == exp_mem, {tag, " memory word"}, mem_arr[addr[5:2]], exp_mem);
        chk(acc_cnt - a0 == exp_acc, {tag, " access count"}, acc_cnt - a0, exp_acc);
        flt_rd = 0; flt_wr = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog expired actual=hung expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem_arr[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R12 reset ready", {31'd0, req_ready}, 1);
        chk({mem_req_valid, done, rd_we, exc_illegal, exc_access, exc_misalign} == '0,
            "R13 reset outputs quiet", {26'd0, mem_req_valid, done, rd_we, exc_illegal,
            exc_access, exc_misalign}, 0);

        run_op("R5 add",          mk(5'h00, 2'b00, 3'd2, 5'd5,  7'h2F), 32'h10, 32'd5,        32'd7,        0, 0, K_DONE);
        run_op("R2 add wrap",     mk(5'h00, 2'b00, 3'd2, 5'd6,  7'h2F), 32'h14, 32'hFFFF_FFFF, 32'd2,       0, 0, K_DONE);
        run_op("R4 xor",          mk(5'h04, 2'b00, 3'd2, 5'd31, 7'h2F), 32'h3C, 32'hF0F0_1234, 32'h0FF0_FFFF, 0, 0, K_DONE);
        run_op("R2 or",           mk(5'h08, 2'b00, 3'd2, 5'd1,  7'h2F), 32'h00, 32'h0000_00F0, 32'h0000_0F0F, 0, 0, K_DONE);
        run_op("R2 and",          mk(5'h0C, 2'b00, 3'd2, 5'd2,  7'h2F), 32'h04, 32'hFF00_FF00, 32'h0F0F_0F0F, 0, 0, K_DONE);
        run_op("R2 min signed",   mk(5'h10, 2'b00, 3'd2, 5'd3,  7'h2F), 32'h08, 32'h8000_0000, 32'd1,       0, 0, K_DONE);
        run_op("R2 max signed",   mk(5'h14, 2'b00, 3'd2, 5'd4,  7'h2F), 32'h08, 32'h8000_0000, 32'd1,       0, 0, K_DONE);
        run_op("R2 min unsigned", mk(5'h18, 2'b00, 3'd2, 5'd7,  7'h2F), 32'h0C, 32'h8000_0000, 32'd1,       0, 0, K_DONE);
        run_op("R2 max unsigned", mk(5'h1C, 2'b00, 3'd2, 5'd8,  7'h2F), 32'h0C, 32'h8000_0000, 32'd1,       0, 0, K_DONE);
        run_op("R10 hint bits",   mk(5'h00, 2'b11, 3'd2, 5'd9,  7'h2F), 32'h18, 32'd100,      32'd23,       0, 0, K_DONE);
        run_op("R9 x0 discard",   mk(5'h08, 2'b00, 3'd2, 5'd0,  7'h2F), 32'h1C, 32'h11,       32'h22,       0, 0, K_DONE);
        run_op("R1 bad funct3",   mk(5'h00, 2'b00, 3'd3, 5'd5,  7'h2F), 32'h20, 32'd9,        32'd1,        0, 0, K_ILL);
        run_op("R1 bad opcode",   mk(5'h00, 2'b00, 3'd2, 5'd5,  7'h33), 32'h20, 32'd9,        32'd1,        0, 0, K_ILL);
        run_op("R3 selector 01",  mk(5'h01, 2'b00, 3'd2, 5'd5,  7'h2F), 32'h20, 32'd9,        32'd1,        0, 0, K_ILL);
        run_op("R3 selector 1F",  mk(5'h1F, 2'b00, 3'd2, 5'd5,  7'h2F), 32'h24, 32'd9,        32'd1,        0, 0, K_ILL);
        run_op("R11 misaligned",  mk(5'h00, 2'b00, 3'd2, 5'd5,  7'h2F), 32'h22, 32'd9,        32'd1,        0, 0, K_MIS);
        run_op("R11 illegal wins",mk(5'h02, 2'b00, 3'd2, 5'd5,  7'h2F), 32'h21, 32'd9,        32'd1,        0, 0, K_ILL);
        run_op("R7 read fault",   mk(5'h00, 2'b00, 3'd2, 5'd5,  7'h2F), 32'h28, 32'd9,        32'd1,        1, 0, K_ACC);
        run_op("R8 write fault",  mk(5'h00, 2'b00, 3'd2, 5'd5,  7'h2F), 32'h2C, 32'd9,        32'd1,        0, 1, K_ACC);

        begin : busy_case
            exp_t e;
            int a0;
            mem_arr[12] = 32'd40;
            a0 = acc_cnt;
            e.kind = K_DONE; e.we = 1'b1; e.idx = 5'd10; e.data = 32'd40; e.tag = "R12 busy op";
            exp_q.push_back(e);
            issue(mk(5'h00, 2'b00, 3'd2, 5'd10, 7'h2F), 32'h30, 32'd2);
            req_valid = 1'b1; req_insn = mk(5'h00, 2'b00, 3'd2, 5'd11, 7'h2F);
            req_rs1_val = 32'h30; req_rs2_val = 32'd1000;
            for (int i = 0; i < 3; i++) begin
                chk(req_ready == 1'b0, "R12 ready low while busy", {31'd0, req_ready}, 0);
                @(negedge clk);
            end
            req_valid = 1'b0;
            while (exp_q.size() != 0) @(negedge clk);
            repeat (4) @(negedge clk);
            chk(mem_arr[12] == 32'd42, "R12 memory after busy", mem_arr[12], 32'd42);
            chk(acc_cnt - a0 == 2, "R12 access count", acc_cnt - a0, 2);
        end

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R12 scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule